// File: doc/BRIEF.md
# Serialized Interrupt Slot Driver

This block sits on the peripheral side of a shared, pulled-up serial interrupt line that runs on the bus clock. It samples the line on every rising edge. A host start frame is a run of at least four low samples followed by a high one. The block then counts three-clock interrupt slots from the last low clock of that start frame. In the sample phase of the slot that belongs to the selected interrupt number, it pulls the line low if any of its request inputs is asserted. It drives the line high for one recovery clock after that, and then releases it.

The block also watches for the stop frame. The width of the stop frame sets the mode of the next cycle. A two-clock stop selects quiet mode, in which the peripheral may open a cycle itself with a one-clock low pulse when a request newly appears on an idle line. A stop of three or more clocks selects continuous mode, in which only the host starts cycles. The line is driven through a drive-enable and drive-value pair, and the pad logic outside the block resolves the line.

Top module: `serirq_slot_drv`

## Requirements
- R1: After reset the block drives nothing (drv_en = 0) and is in continuous mode, so a new request on an idle line produces no start pulse.
- R2: A start frame is recognised only when at least 4 consecutive low samples are followed by a high sample. A shorter low run leaves the block idle, and it drives nothing afterwards.
- R3: Clocks are counted so that the last low clock of the start frame is clock 0. Interrupt n owns slot n+1, whose sample clock is 3n+2. In that single clock the block drives low if a request is asserted, and otherwise leaves the line released.
- R4: In the clock right after its own sample-phase low, the block drives the line high (drv_en = 1, drv_val = 1) for exactly one clock, then releases it.
- R5: Only interrupt numbers 3, 4, 5, 7, 9, 10 and 11 are served. With any other value of irq_num the block never drives a slot.
- R6: With src_act_low = 0 a request is any bit of irq_src that is 1. With src_act_low = 1 a request is any bit that is 0.
- R7: While a cycle is active, a high sample that follows 2 or more low samples ends the cycle. Exactly 2 lows select quiet mode for the next cycle, and 3 or more lows select continuous mode.
- R8: In quiet mode, a request that goes from inactive to active while the line is idle (no cycle, last sample high) makes the block drive low for exactly one clock, starting the clock after the assertion is seen. The block then releases the line.
- R9: No start pulse is issued while a cycle is active, nor in continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Resolved level of the shared interrupt line |
| irq_src | input | NSRC | Interrupt request inputs, combined by OR |
| src_act_low | input | 1 | 1: a request input is asserted when low |
| irq_num | input | 4 | Selected interrupt number |
| drv_en | output | 1 | 1: the block drives the line |
| drv_val | output | 1 | Level driven when drv_en is 1 |

## Verification
A slot counter that is off by one shows at the ports on the first served cycle, as a low pulse one clock early or late next to the expected slot. A wrong recorded mode shows on the first request that rises after the stop frame: a start pulse appears where none should, or the expected pulse is missing. A start frame detected at the wrong threshold either shifts every later slot or produces no slot drive at all. All of these are visible within one interrupt cycle of the fault.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  typedef enum logic {
    LN_IDLE   = 1'b0,
    LN_ACTIVE = 1'b1
  } line_st_e;

  // interrupt numbers this block may own
  function automatic logic irq_supported(input logic [3:0] n);
    case (n)
      4'd3, 4'd4, 4'd5, 4'd7, 4'd9, 4'd10, 4'd11: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // clock (counted from the last start-frame low) of the sample phase for irq n
  function automatic logic [7:0] sample_clk(input logic [3:0] n);
    return ({4'd0, n} * 8'd3) + 8'd2;
  endfunction

endpackage

// File: rtl/serirq_frame_track.sv
module serirq_frame_track
  import serirq_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RUN_W     = 4,
  parameter int START_MIN = 4,
  parameter int STOP_MIN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic             active,
  output logic [CNT_W-1:0] slot_clk,
  output logic             quiet,
  output logic [RUN_W-1:0] low_run
);

  localparam logic [RUN_W-1:0] RUN_MAX   = {RUN_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [RUN_W-1:0] START_LIM = RUN_W'(START_MIN);
  localparam logic [RUN_W-1:0] STOP_LIM  = RUN_W'(STOP_MIN);
  localparam logic [CNT_W-1:0] FIRST_CLK = CNT_W'(2);

  line_st_e st;
  logic     start_end;
  logic     stop_end;

  assign active    = (st == LN_ACTIVE);
  assign start_end = (st == LN_IDLE) && line_in && (low_run >= START_LIM);
  assign stop_end  = active && line_in && (low_run >= STOP_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= LN_IDLE;
      slot_clk <= '0;
      quiet    <= 1'b0;
      low_run  <= '0;
    end else begin
      if (!line_in)
        low_run <= (low_run == RUN_MAX) ? low_run : low_run + 1'b1;
      else
        low_run <= '0;

      if (start_end) begin
        st       <= LN_ACTIVE;
        slot_clk <= FIRST_CLK;
      end else if (stop_end) begin
        st       <= LN_IDLE;
        quiet    <= (low_run == STOP_LIM);
        slot_clk <= '0;
      end else if (active && slot_clk != CNT_MAX) begin
        slot_clk <= slot_clk + 1'b1;
      end
    end
  end

  // R2
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ($past(line_in) && ($past(low_run) >= START_LIM)));

  // R7
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(line_in) && ($past(low_run) >= STOP_LIM)));

endmodule

// File: rtl/serirq_slot_out.sv
module serirq_slot_out
  import serirq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             quiet,
  input  logic             line_in,
  input  logic [RUN_W-1:0] low_run,
  input  logic [CNT_W-1:0] slot_clk,
  input  logic [3:0]       irq_num,
  input  logic             req,
  output logic             drive_lo,
  output logic             drive_hi,
  output logic             start_pulse
);

  logic [CNT_W-1:0] tgt_pre;
  logic             in_slot;
  logic             req_prev;
  logic             req_rise;
  logic             may_start;

  // slot_clk one before the sample clock: the next clock is the sample phase
  assign tgt_pre   = CNT_W'(sample_clk(irq_num) - 8'd1);
  assign in_slot   = active && irq_supported(irq_num) && (slot_clk == tgt_pre);
  assign req_rise  = req && !req_prev;
  assign may_start = !active && quiet && line_in && (low_run == '0) && !start_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_lo    <= 1'b0;
      drive_hi    <= 1'b0;
      start_pulse <= 1'b0;
      req_prev    <= 1'b0;
    end else begin
      drive_lo    <= in_slot && req;
      drive_hi    <= drive_lo;
      start_pulse <= may_start && req_rise;
      req_prev    <= req;
    end
  end

  // R8
  sp_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R4
  recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_lo |=> (drive_hi && !drive_lo));

endmodule

// File: rtl/serirq_slot_drv.sv
module serirq_slot_drv
  import serirq_pkg::*;
#(
  parameter int NSRC      = 4,
  parameter int CNT_W     = 8,
  parameter int RUN_W     = 4,
  parameter int START_MIN = 4,
  parameter int STOP_MIN  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_in,
  input  logic [NSRC-1:0] irq_src,
  input  logic            src_act_low,
  input  logic [3:0]      irq_num,
  output logic            drv_en,
  output logic            drv_val
);

  logic             active;
  logic             quiet;
  logic [CNT_W-1:0] slot_clk;
  logic [RUN_W-1:0] low_run;
  logic             req;
  logic             drive_lo;
  logic             drive_hi;
  logic             start_pulse;

  assign req = |(irq_src ^ {NSRC{src_act_low}});

  serirq_frame_track #(
    .CNT_W(CNT_W), .RUN_W(RUN_W), .START_MIN(START_MIN), .STOP_MIN(STOP_MIN)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .active(active), .slot_clk(slot_clk), .quiet(quiet), .low_run(low_run)
  );

  serirq_slot_out #(
    .CNT_W(CNT_W), .RUN_W(RUN_W)
  ) u_out (
    .clk(clk), .rst_n(rst_n), .active(active), .quiet(quiet),
    .line_in(line_in), .low_run(low_run), .slot_clk(slot_clk),
    .irq_num(irq_num), .req(req),
    .drive_lo(drive_lo), .drive_hi(drive_hi), .start_pulse(start_pulse)
  );

  assign drv_en  = drive_lo | drive_hi | start_pulse;
  assign drv_val = drive_hi;

  // R9
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !active);

  // R5
  drive_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !drv_val && !start_pulse) |-> $past(active));

endmodule

// File: tb/serirq_slot_drv_test.sv
`timescale 1ns/1ps
module serirq_slot_drv_test;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic [NSRC-1:0] src;
  logic            act_low;
  logic [3:0]      num;
  logic            drv_en, drv_val;
  logic            host_en, host_val;
  wire line = drv_en ? drv_val : (host_en ? host_val : 1'b1);

  serirq_slot_drv #(.NSRC(NSRC)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .irq_src(src),
    .src_act_low(act_low), .irq_num(num), .drv_en(drv_en), .drv_val(drv_val)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done = 0, mon_on = 0;
  int exp_lo_at = -1, exp_hi_at = -1, exp_sp_at = -1;
  int e0 = 0;
  string phase = "R1";

  // behavioural schedule model, compared on every clock
  always @(negedge clk) begin
    logic ee, ev;
    if (mon_on) begin
      ee = (cyc == exp_lo_at) || (cyc == exp_hi_at) || (cyc == exp_sp_at);
      ev = (cyc == exp_hi_at);
      checks++;
      if (drv_en !== ee || (ee && drv_val !== ev)) begin
        fails++;
        $display("FAIL %s cyc=%0d en/val act=%b/%b exp=%b/%b", phase, cyc, drv_en, drv_val, ee, ev);
      end
    end
  end

  function automatic int slot_sample(input int n);
    return 3 * (n + 1) - 1;
  endfunction

  task automatic host_pulse(input int lows);
    for (int i = 0; i < lows; i++) begin
      @(negedge clk); host_en = 1'b1; host_val = 1'b0;
    end
    e0 = cyc + 1;
    @(negedge clk); host_val = 1'b1;
    @(negedge clk); host_en = 1'b0;
  endtask

  task automatic expect_slot(input int n);
    exp_lo_at = e0 + slot_sample(n) - 1;
    exp_hi_at = exp_lo_at + 1;
  endtask

  task automatic close_cycle(input int stop_len);
    while (cyc < e0 + 40) @(negedge clk);
    host_pulse(stop_len);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nums[7] = '{3, 4, 5, 7, 9, 10, 11};
    int bad[3]  = '{6, 8, 0};
    rst_n = 1'b0; src = '0; act_low = 1'b0; num = 4'd3;
    host_en = 1'b0; host_val = 1'b1;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    check1("R1 reset drv_en", drv_en, 1'b0);
    mon_on = 1;

    // R1/R9: continuous after reset, rising request gives no start pulse
    phase = "R1"; idle(3); src = 4'b0001; idle(6); src = '0; idle(3);

    // R2: three lows are not a start frame
    phase = "R2"; num = 4'd3; src = 4'b0001;
    host_pulse(3); idle(45);

    // R3/R4: every supported number, varied start length and source bit
    phase = "R3";
    for (int k = 0; k < 7; k++) begin
      num = 4'(nums[k]); src = 4'(1 << (k % NSRC));
      host_pulse(4 + (k % 5)); expect_slot(nums[k]);
      close_cycle(3);
    end
    phase = "R3 no request"; src = '0; num = 4'd5;
    host_pulse(5); close_cycle(3);

    // R5: unsupported numbers never drive
    phase = "R5"; src = 4'b0010;
    for (int k = 0; k < 3; k++) begin
      num = 4'(bad[k]); host_pulse(4); close_cycle(3);
    end

    // R6: polarity
    phase = "R6"; num = 4'd4; act_low = 1'b1; src = 4'b1111;
    host_pulse(4); close_cycle(3);
    src = 4'b1011; host_pulse(6); expect_slot(4); close_cycle(3);
    src = 4'b1111; idle(2); act_low = 1'b0; src = '0; idle(3);

    // R7/R8: two-clock stop selects quiet; rising request self-starts
    phase = "R7"; num = 4'd7;
    host_pulse(4); close_cycle(2);
    phase = "R8"; src = 4'b0100; exp_sp_at = cyc + 1;
    @(negedge clk);
    check1("R8 start pulse low", drv_en && !drv_val, 1'b1);
    host_pulse(3); expect_slot(7);
    while (cyc <= exp_hi_at + 1) @(negedge clk);
    // R9: new assertion during an active cycle is not a start request
    phase = "R9"; src = '0; @(negedge clk); src = 4'b0100;
    close_cycle(3);
    // R7: three-clock stop gives continuous, no self-start
    phase = "R7"; src = '0; idle(2); src = 4'b0001; idle(6); src = '0;
    host_pulse(4); close_cycle(2);
    phase = "R8"; src = 4'b1000; exp_sp_at = cyc + 1; idle(8);
    phase = "R7"; src = '0;
    host_pulse(5); close_cycle(4);
    src = 4'b0001; idle(8);

    mon_on = 0; done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule